// File: doc/BRIEF.md
# Programmable Test Pattern Generator

This block produces the transmit stream for a bit error rate test. A single 32-bit feedback register serves three jobs. It runs two-tap pseudo-random sequences, with the taps either chosen by the host or taken from three fixed presets. It runs a quasi-random sequence that limits runs of zeros. It also loops a programmed word of 1 to 32 bits. While the test is enabled, the generated bit replaces the normal serial traffic. When the test is disabled, the traffic passes through unchanged.

A data-enable strobe gaps the stream, and the register advances only on strobed cycles. On request, one transmitted bit is inverted so that the far-end checker can be shown to count errors. The register is reseeded when the test is off and whenever the configuration changes. A test therefore always starts from a known point.

Top module: `prbs_pattern_gen`

## Requirements
- R1: While `en_i` is 0, `data_o` equals `traffic_i` and the register is held at its seed. While `en_i` is 1, `data_o` carries the generated bit.
- R2: For `mode_i` 1, 2 and 3, the sequence is x^9+x^5+1, x^15+x^14+1 and x^23+x^18+1. The register is seeded with all ones and shifts from bit 1 toward bit 32. The feedback enters bit 1, and the feedback bit is the transmitted bit.
- R3: For `mode_i` 0, 6 or 7, the feedback is the XOR of bit `tap_n_i` and bit `tap_y_i`, each numbered 1 to 32.
- R4: In every mode except repetitive, the feedback is forced to 1 whenever bits 1 to 31 are all zero.
- R5: For `mode_i` 4 (quasi-random), the feedback is the XOR of bits 17 and 20. The transmitted bit is forced to 1 whenever bits 1 to 14 are all zero, and the register still takes the unforced feedback.
- R6: For `mode_i` 5 (repetitive), the register is seeded with `pattern_i` and the feedback is bit `tap_n_i`. The output repeats `pattern_i[n-1]` down to `pattern_i[0]` with period n.
- R7: A cycle with `data_en_i` at 0 neither advances the register nor consumes a pending error.
- R8: A rising edge on `err_req_i` inverts exactly one transmitted bit. That bit is the first one taken in a cycle after the edge, and the register sequence is not disturbed.
- R9: A change of `mode_i`, `tap_n_i`, `tap_y_i` or `pattern_i` while enabled reseeds the register at the next clock edge. No bit is taken in that cycle.
- R10: After reset, the register holds all ones, no error is pending, and the output follows `traffic_i` while disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Test enable; overrides normal traffic |
| data_en_i | input | 1 | Bit strobe; low cycles gap the stream |
| mode_i | input | 3 | 0 custom, 1 PRBS9, 2 PRBS15, 3 PRBS23, 4 quasi-random, 5 repetitive |
| tap_n_i | input | 6 | First tap, or repetitive length (1..32) |
| tap_y_i | input | 6 | Second tap for custom mode (1..32) |
| pattern_i | input | 32 | Repetitive pattern word |
| err_req_i | input | 1 | Single error insert request (edge sensitive) |
| traffic_i | input | 1 | Normal payload bit |
| data_o | output | 1 | Payload bit out |

## Verification
A wrong tap index or a missing lock guard corrupts the stream within one register length of the reseed. Most faults show far sooner, because the first 32 bits after a reseed already depend on every tap. A register that advances on a gapped cycle, or that misses a reseed, shifts the whole remaining sequence, so the next strobed bit is already wrong. A badly handled error request shows up as no inverted bit, or as a second inverted bit, in the first few strobed cycles after the edge.

// File: rtl/prbs_gen_pkg.sv
package prbs_gen_pkg;
  localparam int STATE_W = 32;
  localparam int IDX_W   = $clog2(STATE_W);
  localparam int TAP_W   = IDX_W + 1;
  localparam int MODE_W  = 3;
  localparam int QRSS_RUN = 14;

  typedef enum logic [MODE_W-1:0] {
    MODE_CUSTOM = 3'd0,
    MODE_PRBS9  = 3'd1,
    MODE_PRBS15 = 3'd2,
    MODE_PRBS23 = 3'd3,
    MODE_QRSS   = 3'd4,
    MODE_REPEAT = 3'd5
  } gen_mode_e;
endpackage

// File: rtl/prbs_cfg_ctrl.sv
module prbs_cfg_ctrl
  import prbs_gen_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [MODE_W-1:0]  mode_i,
  input  logic [TAP_W-1:0]   tap_n_i,
  input  logic [TAP_W-1:0]   tap_y_i,
  input  logic [STATE_W-1:0] pattern_i,
  output logic [IDX_W-1:0]   idx_a_o,
  output logic [IDX_W-1:0]   idx_b_o,
  output logic               rep_o,
  output logic               qrss_o,
  output logic               chg_o
);
  localparam int CFG_W = MODE_W + 2*TAP_W + STATE_W;

  logic [TAP_W-1:0] n_m1, y_m1;
  logic [CFG_W-1:0] cfg_now, cfg_q;

  assign n_m1 = tap_n_i - TAP_W'(1);
  assign y_m1 = tap_y_i - TAP_W'(1);

  // zero-based tap indices
  always_comb begin
    rep_o  = 1'b0;
    qrss_o = 1'b0;
    idx_a_o = n_m1[IDX_W-1:0];
    idx_b_o = y_m1[IDX_W-1:0];
    case (mode_i)
      MODE_PRBS9:  begin idx_a_o = IDX_W'(8);  idx_b_o = IDX_W'(4);  end
      MODE_PRBS15: begin idx_a_o = IDX_W'(14); idx_b_o = IDX_W'(13); end
      MODE_PRBS23: begin idx_a_o = IDX_W'(22); idx_b_o = IDX_W'(17); end
      MODE_QRSS: begin
        idx_a_o = IDX_W'(19);
        idx_b_o = IDX_W'(16);
        qrss_o  = 1'b1;
      end
      MODE_REPEAT: begin
        idx_b_o = n_m1[IDX_W-1:0];
        rep_o   = 1'b1;
      end
      default: ;
    endcase
  end

  assign cfg_now = {mode_i, tap_n_i, tap_y_i, pattern_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_now;
  end

  assign chg_o = (cfg_now != cfg_q);
endmodule

// File: rtl/prbs_lfsr_core.sv
module prbs_lfsr_core
  import prbs_gen_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [STATE_W-1:0] seed_i,
  input  logic               adv_i,
  input  logic [IDX_W-1:0]   idx_a_i,
  input  logic [IDX_W-1:0]   idx_b_i,
  input  logic               rep_i,
  input  logic               qrss_i,
  output logic               bit_o
);
  logic [STATE_W-1:0] s_q;
  logic fb_raw, fb, lock, zero_run;

  assign fb_raw   = rep_i ? s_q[idx_a_i] : (s_q[idx_a_i] ^ s_q[idx_b_i]);
  assign lock     = ~rep_i & (s_q[STATE_W-2:0] == '0);
  assign fb       = lock | fb_raw;
  assign zero_run = qrss_i & (s_q[QRSS_RUN-1:0] == '0);
  assign bit_o    = fb | zero_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     s_q <= '1;
    else if (load_i) s_q <= seed_i;
    else if (adv_i)  s_q <= {s_q[STATE_W-2:0], fb};
  end

  a_r2_shift_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i |=> s_q[STATE_W-1:1] == $past(s_q[STATE_W-2:0]));
  a_r7_gap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i && !load_i |=> $stable(s_q));
  a_r4_no_lockup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i && !rep_i && s_q[STATE_W-2:0] == '0 |=> s_q[0]);
  a_r9_reseed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> s_q == $past(seed_i));
endmodule

// File: rtl/prbs_err_inject.sv
module prbs_err_inject (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic take_i,
  output logic flip_o
);
  logic req_q, pend_q;

  assign flip_o = pend_q & take_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_q  <= req_i;
      pend_q <= (req_i & ~req_q) | (pend_q & ~take_i);
    end
  end

  a_r8_req_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_i) |=> pend_q);
  a_r8_single_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flip_o && !(req_i && !req_q) |=> !pend_q);
endmodule

// File: rtl/prbs_pattern_gen.sv
module prbs_pattern_gen
  import prbs_gen_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               data_en_i,
  input  logic [MODE_W-1:0]  mode_i,
  input  logic [TAP_W-1:0]   tap_n_i,
  input  logic [TAP_W-1:0]   tap_y_i,
  input  logic [STATE_W-1:0] pattern_i,
  input  logic               err_req_i,
  input  logic               traffic_i,
  output logic               data_o
);
  logic [IDX_W-1:0] idx_a, idx_b;
  logic rep, qrss, chg, load, adv, gen_bit, flip;
  logic [STATE_W-1:0] seed;

  prbs_cfg_ctrl u_cfg (
    .clk_i, .rst_ni, .mode_i, .tap_n_i, .tap_y_i, .pattern_i,
    .idx_a_o(idx_a), .idx_b_o(idx_b), .rep_o(rep), .qrss_o(qrss), .chg_o(chg)
  );

  // seed continuously while off; reseed on any config edit
  assign seed = rep ? pattern_i : '1;
  assign load = ~en_i | chg;
  assign adv  = en_i & data_en_i & ~chg;

  prbs_lfsr_core u_core (
    .clk_i, .rst_ni, .load_i(load), .seed_i(seed), .adv_i(adv),
    .idx_a_i(idx_a), .idx_b_i(idx_b), .rep_i(rep), .qrss_i(qrss),
    .bit_o(gen_bit)
  );

  prbs_err_inject u_err (
    .clk_i, .rst_ni, .req_i(err_req_i), .take_i(adv), .flip_o(flip)
  );

  assign data_o = en_i ? (gen_bit ^ flip) : traffic_i;
endmodule

// File: tb/tb_prbs_pattern_gen.sv
module tb_prbs_pattern_gen;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic en = 1'b0, de = 1'b0, err = 1'b0, trf = 1'b0;
  logic [2:0] mode = 3'd1;
  logic [5:0] tn = 6'd9, ty = 6'd5;
  logic [31:0] pat = '0;
  logic data_o;

  int checks = 0, failures = 0;
  bit done = 0;

  bit    exp_q[$];
  string tag_q[$];

  bit [31:0] m_s = '1;
  bit m_pend = 0, m_err_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prbs_pattern_gen dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .data_en_i(de),
    .mode_i(mode), .tap_n_i(tn), .tap_y_i(ty), .pattern_i(pat),
    .err_req_i(err), .traffic_i(trf), .data_o(data_o)
  );

  function automatic void taps(output int a, output int b, output bit rep, output bit q);
    rep = 0; q = 0; a = int'(tn) - 1; b = int'(ty) - 1;
    case (mode)
      3'd1: begin a = 8;  b = 4;  end
      3'd2: begin a = 14; b = 13; end
      3'd3: begin a = 22; b = 17; end
      3'd4: begin a = 19; b = 16; q = 1; end
      3'd5: begin b = a; rep = 1; end
      default: ;
    endcase
  endfunction

  function automatic bit ref_fb();
    int a, b; bit rep, q, f;
    taps(a, b, rep, q);
    f = rep ? m_s[a] : (m_s[a] ^ m_s[b]);
    if (!rep && m_s[30:0] == 0) f = 1;
    return f;
  endfunction

  function automatic bit ref_out();
    int a, b; bit rep, q;
    taps(a, b, rep, q);
    if (q && m_s[13:0] == 0) return 1'b1;
    return ref_fb();
  endfunction

  function automatic void reseed();
    m_s = (mode == 3'd5) ? pat : 32'hFFFF_FFFF;
  endfunction

  task automatic check(input string tag, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: data_o=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: one cycle, pushes the expected bit when a bit is taken
  task automatic step(input bit d, input bit e, input string tag);
    bit o, f;
    @(posedge clk); #1;
    de = d; err = e;
    if (d && en) begin
      o = ref_out();
      f = ref_fb();
      if (m_pend) begin o = ~o; m_pend = 0; end
      exp_q.push_back(o); tag_q.push_back(tag);
      m_s = {m_s[30:0], f};
    end
    if (e && !m_err_prev) m_pend = 1;
    m_err_prev = e;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, 0, tag);
  endtask

  // config edit with strobe low; the next edge reseeds
  task automatic set_cfg(input logic [2:0] md, input logic [5:0] n, input logic [5:0] y,
                         input logic [31:0] p);
    @(posedge clk); #1;
    de = 0; err = 0; m_err_prev = 0;
    mode = md; tn = n; ty = y; pat = p;
    reseed();
  endtask

  task automatic set_en(input bit v);
    @(posedge clk); #1;
    de = 0; err = 0; m_err_prev = 0;
    en = v;
    reseed();
  endtask

  // monitor: pops expected bits mid-cycle
  always @(negedge clk) begin
    if (rst_ni && en && de && !done) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL scoreboard: unexpected bit %0b at %0t", data_o, $time);
      end else begin
        check(tag_q.pop_front(), data_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R10 / R1: bypass during and after reset
    #2; trf = 1; #1; check("R10", data_o, 1'b1);
    trf = 0; #1; check("R10", data_o, 1'b0);
    #(CLK_PERIOD*3); rst_ni = 1;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1; trf = i[0]; de = 1;
      @(negedge clk); check("R1", data_o, trf);
    end
    de = 0;

    // R10: first enable after reset starts from all ones (PRBS9 preset)
    set_en(1);
    run(600, "R2");                      // R2 PRBS9 with R10 seed
    set_cfg(3'd2, 6'd1, 6'd1, '0); run(300, "R2");
    set_cfg(3'd3, 6'd1, 6'd1, '0); run(300, "R2");

    // R3 custom taps
    set_cfg(3'd0, 6'd7, 6'd6, '0);  run(200, "R3");
    set_cfg(3'd0, 6'd32, 6'd1, '0); run(200, "R3");
    set_cfg(3'd7, 6'd11, 6'd2, '0); run(100, "R3");

    // R4 equal taps drive zeros until the lock guard fires
    set_cfg(3'd0, 6'd5, 6'd5, '0); run(100, "R4");

    // R5 quasi-random
    set_cfg(3'd4, 6'd1, 6'd1, '0); run(2000, "R5");

    // R6 repetitive
    set_cfg(3'd5, 6'd8, 6'd1, 32'h0000_00A7);  run(40, "R6");
    set_cfg(3'd5, 6'd1, 6'd1, 32'h0000_0001);  run(8, "R6");
    set_cfg(3'd5, 6'd32, 6'd1, 32'hDEAD_BEEF); run(70, "R6");

    // R7 gapping
    set_cfg(3'd2, 6'd1, 6'd1, '0);
    for (int i = 0; i < 200; i++) step((i % 3) != 1, 0, "R7");
    for (int i = 0; i < 5; i++) step(0, 0, "R7");
    run(20, "R7");

    // R8 error insertion
    set_cfg(3'd1, 6'd1, 6'd1, '0);
    run(10, "R8");
    step(0, 1, "R8"); run(10, "R8");          // single pulse, strobe low
    step(1, 1, "R8"); run(10, "R8");          // pulse on a strobed cycle
    for (int i = 0; i < 6; i++) step(1, 1, "R8");  // held high: one flip
    step(0, 0, "R8");
    step(0, 1, "R8"); step(0, 0, "R8"); step(0, 0, "R8"); run(10, "R8");  // R7 gap keeps error pending

    // R9 mid-stream config change
    set_cfg(3'd5, 6'd12, 6'd1, 32'h0000_0ABC); run(17, "R9");
    set_cfg(3'd5, 6'd12, 6'd1, 32'h0000_0531); run(30, "R9");
    set_cfg(3'd2, 6'd12, 6'd1, 32'h0000_0531); run(40, "R9");

    // R1 disable mid-stream, then re-enable restarts from seed
    set_en(0);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1; trf = ~i[1]; de = 1;
      @(negedge clk); check("R1", data_o, trf);
    end
    set_en(1); run(50, "R1");

    @(posedge clk); #1; de = 0;
    @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL scoreboard: %0d bits never seen, expected 0", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule